// File: doc/BRIEF.md
# I2C Downstream Bus Switch

This block is an I2C target that fans one upstream SDA/SCL pair out to a set of downstream pairs. It holds a channel-selection register that the bus master writes through the upstream pair. Every selected channel is joined to the upstream pair as if by a wire. A low driven by the master, or by any device on a joined channel, appears on every other joined side. Channels that are not selected are isolated, so devices with the same address can sit on different channels, and a large bus can be split into smaller loads.

A parameter picks one of two selection rules. In mux mode at most one channel can be joined at a time. In switch mode any subset can be joined. All bus pins are open-drain: each has an input, which passes through a synchronizer, and an output enable that pulls the line low. Each channel also has an active-low interrupt input. These inputs are combined, without latching, into one active-low interrupt output and into a status field the master can read. Three strap pins set the low address bits, so eight copies can share one bus. A synchronous system reset and an active-low hardware reset pin both clear the selection.

Top module: `i2c_bus_switch`

## Requirements
- R1: The block acknowledges the 7-bit address {4'b1110, addr_sel}. A transfer to any other address gets no acknowledge and leaves the selection unchanged.
- R2: In switch mode (SWITCH_MODE=1), a written data byte joins channel k when its bit k is 1. Any combination of channels can be joined.
- R3: In mux mode (SWITCH_MODE=0, 4 channels), bit 2 of the written byte is the enable and bits 1:0 are the channel index. At most one channel is ever driven. With the enable at 0, no channel is joined.
- R4: A written selection is held back while the transfer runs and takes effect only at the STOP condition.
- R5: rst high, or hw_rst_n low (synchronized), clears the selection. No channel is joined afterwards and the read-back selection is 0.
- R6: A low on the upstream line is driven onto every joined channel's line. The output enable rises on the third clock edge after the line falls.
- R7: A low driven by a device on a joined channel is driven onto the upstream line and onto the other joined channels.
- R8: A channel that is not joined is never driven, and a low on it has no effect on the upstream line.
- R9: irq_n_o is the AND of all irq_n_i inputs and is not latched. It changes on the third clock edge after an input changes.
- R10: A read returns one byte. Bits 7:4 hold a 1 in bit 4+k for each channel k whose interrupt input is low. Bits 3:0 hold the current selection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high system reset (power-on) |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin |
| addr_sel | input | 3 | Strap pins giving the low three address bits |
| scl_up_i | input | 1 | Upstream SCL line level |
| sda_up_i | input | 1 | Upstream SDA line level |
| scl_up_oe | output | 1 | Pull upstream SCL low |
| sda_up_oe | output | 1 | Pull upstream SDA low |
| scl_dn_i | input | NUM_CH | Downstream SCL line levels |
| sda_dn_i | input | NUM_CH | Downstream SDA line levels |
| scl_dn_oe | output | NUM_CH | Pull downstream SCL lines low |
| sda_dn_oe | output | NUM_CH | Pull downstream SDA lines low |
| irq_n_i | input | NUM_CH | Per-channel active-low interrupt inputs |
| irq_n_o | output | 1 | Combined active-low interrupt |

## Verification
Every path from a pin to a pin passes two synchronizer flops and one output register. A pull on the upstream line, and an edge on an interrupt input, therefore shows at the ports on the third rising edge after the change. The bench changes the input just after a falling edge. It samples just after the second falling edge, where the old value must still hold, and again just after the third, where the new value must show. Checks that do not need exact timing, such as the upward path through the bridge state machine and the results of read and write transfers, wait several quarter-bit periods before sampling. A selection is probed while SCL is held low mid-transfer, before the STOP, to show that the new value is not yet in effect.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
  // fixed upper bits of the target address
  localparam logic [3:0] ADDR_FIXED = 4'b1110;

  typedef enum logic [2:0] {
    T_IDLE, T_ADDR, T_ACKA, T_WDAT, T_ACKW, T_RDAT, T_RACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    B_IDLE, B_UPL, B_DNL, B_HOLD
  } brg_state_t;
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  // open-drain lines idle high, so reset to all ones
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2csw_bridge.sv
module i2csw_bridge
  import i2csw_pkg::*;
#(
  parameter int N        = 4,
  parameter int HOLD_CYC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_s,
  input  logic [N-1:0] dn_s,
  input  logic [N-1:0] conn,
  output logic         up_oe,
  output logic [N-1:0] dn_oe
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  brg_state_t       st;
  logic [N-1:0]     lead;
  logic [CNT_W-1:0] cnt;
  logic [N-1:0]     dn_low;

  assign dn_low = ~dn_s & conn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= B_IDLE;
      lead  <= '0;
      cnt   <= '0;
      up_oe <= 1'b0;
      dn_oe <= '0;
    end else begin
      case (st)
        B_IDLE: begin
          if (!up_s) begin
            st    <= B_UPL;
            dn_oe <= conn;
          end else if (|dn_low) begin
            st    <= B_DNL;
            lead  <= dn_low;
            up_oe <= 1'b1;
            dn_oe <= conn & ~dn_low;
          end
        end
        B_UPL: begin
          if (up_s) begin
            st    <= B_HOLD;
            dn_oe <= '0;
            cnt   <= '0;
          end else begin
            dn_oe <= conn;
          end
        end
        B_DNL: begin
          if (!(|(lead & dn_low))) begin
            st    <= B_HOLD;
            up_oe <= 1'b0;
            dn_oe <= '0;
            cnt   <= '0;
          end else begin
            lead  <= lead & conn;
            dn_oe <= conn & ~lead;
          end
        end
        B_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) st <= B_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  assert_up_to_dn_R6: assert property (@(posedge clk) disable iff (rst)
    (st == B_IDLE && !up_s) |=> (dn_oe == $past(conn)));

  assert_dn_to_up_R7: assert property (@(posedge clk) disable iff (rst)
    (st == B_IDLE && up_s && (|dn_low)) |=> up_oe);

  assert_isolated_R8: assert property (@(posedge clk) disable iff (rst)
    (st != B_IDLE) |=> ((dn_oe & ~$past(conn)) == '0));
endmodule

// File: rtl/i2csw_target.sv
module i2csw_target
  import i2csw_pkg::*;
#(
  parameter int NGRP  = 1,
  parameter int GRP_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       rd_byte,
  output logic             sda_oe,
  output logic [7:0]       wr_byte,
  output logic             wr_commit,
  output logic [GRP_W-1:0] rd_idx
);
  tgt_state_t st;
  logic       scl_q, sda_q, rw, nack, pend_v;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; rw <= 1'b0; nack <= 1'b1;
      pend_v <= 1'b0; cnt <= '0; sh <= '0; sda_oe <= 1'b0; wr_byte <= '0;
      wr_commit <= 1'b0; rd_idx <= '0;
    end else begin
      scl_q     <= scl_s;
      sda_q     <= sda_s;
      wr_commit <= 1'b0;
      if (start_c) begin
        st <= T_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= T_IDLE; sda_oe <= 1'b0;
        if (pend_v) begin wr_commit <= 1'b1; pend_v <= 1'b0; end
      end else begin
        case (st)
          T_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == dev_addr) begin
                st <= T_ACKA; sda_oe <= 1'b1; rw <= sh[0]; rd_idx <= '0;
              end else begin
                st <= T_IDLE;
              end
            end
          end
          T_ACKA: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin st <= T_RDAT; sh <= rd_byte; sda_oe <= ~rd_byte[7]; end
            else begin st <= T_WDAT; sda_oe <= 1'b0; end
          end
          T_WDAT: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              wr_byte <= sh; pend_v <= 1'b1; sda_oe <= 1'b1; st <= T_ACKW;
            end
          end
          T_ACKW: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; st <= T_WDAT;
          end
          T_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= T_RACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
              end
            end
          end
          T_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
              if (!sda_s) rd_idx <= (rd_idx == GRP_W'(NGRP - 1)) ? '0 : rd_idx + GRP_W'(1);
            end else if (scl_fall) begin
              if (nack) st <= T_IDLE;
              else begin st <= T_RDAT; cnt <= '0; sh <= rd_byte; sda_oe <= ~rd_byte[7]; end
            end
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_bus_switch.sv
module i2c_bus_switch
  import i2csw_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter bit SWITCH_MODE = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_rst_n,
  input  logic [2:0]        addr_sel,
  input  logic              scl_up_i,
  input  logic              sda_up_i,
  output logic              scl_up_oe,
  output logic              sda_up_oe,
  input  logic [NUM_CH-1:0] scl_dn_i,
  input  logic [NUM_CH-1:0] sda_dn_i,
  output logic [NUM_CH-1:0] scl_dn_oe,
  output logic [NUM_CH-1:0] sda_dn_oe,
  input  logic [NUM_CH-1:0] irq_n_i,
  output logic              irq_n_o
);
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int EN_BIT   = (IDX_W < 2) ? 2 : IDX_W;
  localparam int CTRL_W   = SWITCH_MODE ? NUM_CH : EN_BIT + 1;
  localparam int NGRP     = (NUM_CH + 3) / 4;
  localparam int GRP_W    = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int PAD_W    = NGRP * 4;
  localparam int HOLD_CYC = SYNC_STAGES + 2;
  localparam int SW       = 3 + 3 * NUM_CH;

  logic [SW-1:0]     sync_q;
  logic              hw_s, scl_up_s, sda_up_s, rst_any;
  logic [NUM_CH-1:0] scl_dn_s, sda_dn_s, irq_s, conn;
  logic [CTRL_W-1:0] ctrl;
  logic [7:0]        wr_byte, rd_byte;
  logic              wr_commit, tgt_sda_oe, brg_sda_up_oe;
  logic [GRP_W-1:0]  rd_idx;
  logic [PAD_W-1:0]  sel_pad, irq_pad;
  logic              unused_wr;

  i2csw_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({hw_rst_n, scl_up_i, sda_up_i, scl_dn_i, sda_dn_i, irq_n_i}),
    .q(sync_q)
  );
  assign {hw_s, scl_up_s, sda_up_s, scl_dn_s, sda_dn_s, irq_s} = sync_q;
  assign rst_any = rst | ~hw_s;

  i2csw_target #(.NGRP(NGRP), .GRP_W(GRP_W)) u_tgt (
    .clk(clk), .rst(rst_any), .scl_s(scl_up_s), .sda_s(sda_up_s),
    .dev_addr({ADDR_FIXED, addr_sel}), .rd_byte(rd_byte), .sda_oe(tgt_sda_oe),
    .wr_byte(wr_byte), .wr_commit(wr_commit), .rd_idx(rd_idx)
  );

  // selection register, loaded only when a STOP closes a write
  always_ff @(posedge clk) begin
    if (rst_any) ctrl <= '0;
    else if (wr_commit) ctrl <= wr_byte[CTRL_W-1:0];
  end
  assign unused_wr = ^wr_byte;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_conn
    if (SWITCH_MODE) begin : g_sw
      assign conn[k] = ctrl[k];
    end else begin : g_mx
      assign conn[k] = ctrl[EN_BIT] && (ctrl[IDX_W-1:0] == IDX_W'(k));
    end
  end

  assign sel_pad = PAD_W'(ctrl);
  assign irq_pad = PAD_W'(~irq_s);
  assign rd_byte = {irq_pad[{rd_idx, 2'b00} +: 4], sel_pad[{rd_idx, 2'b00} +: 4]};

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else irq_n_o <= &irq_s;
  end

  i2csw_bridge #(.N(NUM_CH), .HOLD_CYC(HOLD_CYC)) u_scl_brg (
    .clk(clk), .rst(rst_any), .up_s(scl_up_s), .dn_s(scl_dn_s), .conn(conn),
    .up_oe(scl_up_oe), .dn_oe(scl_dn_oe)
  );

  i2csw_bridge #(.N(NUM_CH), .HOLD_CYC(HOLD_CYC)) u_sda_brg (
    .clk(clk), .rst(rst_any), .up_s(sda_up_s), .dn_s(sda_dn_s), .conn(conn),
    .up_oe(brg_sda_up_oe), .dn_oe(sda_dn_oe)
  );

  assign sda_up_oe = brg_sda_up_oe | tgt_sda_oe;

  if (!SWITCH_MODE) begin : g_mx_chk
    assert_single_channel_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(scl_dn_oe) && $onehot0(sda_dn_oe));
  end

  assert_commit_at_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl != $past(ctrl)) |-> $past(wr_commit || !hw_s));

  assert_hw_reset_clears_R5: assert property (@(posedge clk) disable iff (rst)
    !hw_s |=> (ctrl == '0));
endmodule

// File: tb/i2c_bus_switch_tb_top.sv
module i2c_bus_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;
  localparam int WATCHDOG   = 150000;
  localparam logic [6:0] SW_ADDR = 7'h70;
  localparam logic [6:0] MX_ADDR = 7'h75;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1, sw_hw_rst_n = 1'b1;
  logic m_scl = 1'b0, m_sda = 1'b0;
  logic [3:0] sw_dev_scl = '0, sw_dev_sda = '0, mx_dev_scl = '0, mx_dev_sda = '0;
  logic [3:0] sw_irq_n = 4'hF, mx_irq_n = 4'hF;
  logic sw_scl_up_oe, sw_sda_up_oe, mx_scl_up_oe, mx_sda_up_oe, sw_irq_o, mx_irq_o;
  logic [3:0] sw_scl_dn_oe, sw_sda_dn_oe, mx_scl_dn_oe, mx_sda_dn_oe;
  logic scl_up, sda_up;
  logic [3:0] sw_scl_dn, sw_sda_dn, mx_scl_dn, mx_sda_dn;

  assign scl_up    = ~(m_scl | sw_scl_up_oe | mx_scl_up_oe);
  assign sda_up    = ~(m_sda | sw_sda_up_oe | mx_sda_up_oe);
  assign sw_scl_dn = ~(sw_scl_dn_oe | sw_dev_scl);
  assign sw_sda_dn = ~(sw_sda_dn_oe | sw_dev_sda);
  assign mx_scl_dn = ~(mx_scl_dn_oe | mx_dev_scl);
  assign mx_sda_dn = ~(mx_sda_dn_oe | mx_dev_sda);

  i2c_bus_switch #(.NUM_CH(4), .SWITCH_MODE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .hw_rst_n(sw_hw_rst_n), .addr_sel(3'b000),
    .scl_up_i(scl_up), .sda_up_i(sda_up), .scl_up_oe(sw_scl_up_oe), .sda_up_oe(sw_sda_up_oe),
    .scl_dn_i(sw_scl_dn), .sda_dn_i(sw_sda_dn), .scl_dn_oe(sw_scl_dn_oe), .sda_dn_oe(sw_sda_dn_oe),
    .irq_n_i(sw_irq_n), .irq_n_o(sw_irq_o));

  i2c_bus_switch #(.NUM_CH(4), .SWITCH_MODE(1'b0)) dut_mux_i (
    .clk(clk), .rst(rst), .hw_rst_n(1'b1), .addr_sel(3'b101),
    .scl_up_i(scl_up), .sda_up_i(sda_up), .scl_up_oe(mx_scl_up_oe), .sda_up_oe(mx_sda_up_oe),
    .scl_dn_i(mx_scl_dn), .sda_dn_i(mx_sda_dn), .scl_dn_oe(mx_scl_dn_oe), .sda_dn_oe(mx_sda_dn_oe),
    .irq_n_i(mx_irq_n), .irq_n_o(mx_irq_o));

  int checks = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master pin model: 1 = pull the line low
  task automatic i2c_start();
    m_sda = 1'b1; wait_cyc(Q); m_scl = 1'b1; wait_cyc(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b1; wait_cyc(Q); m_scl = 1'b0; wait_cyc(Q); m_sda = 1'b0; wait_cyc(2*Q);
  endtask

  task automatic bit_out(input logic b);
    m_sda = ~b; wait_cyc(Q); m_scl = 1'b0; wait_cyc(2*Q); m_scl = 1'b1; wait_cyc(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b0; wait_cyc(Q); m_scl = 1'b0; wait_cyc(Q); b = sda_up;
    wait_cyc(Q); m_scl = 1'b1; wait_cyc(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(last);
  endtask

  task automatic write_sel(input logic [6:0] a, input logic [7:0] d, output logic ack);
    logic ack2;
    i2c_start();
    wbyte({a, 1'b0}, ack);
    if (ack) wbyte(d, ack2);
    i2c_stop();
  endtask

  task automatic read_stat(input logic [6:0] a, output logic [7:0] d);
    logic ack;
    i2c_start();
    wbyte({a, 1'b1}, ack);
    if (ack) rbyte(1'b1, d); else d = 8'hEE;
    i2c_stop();
  endtask

  // pull upstream SCL and report downstream SCL levels of both instances
  task automatic probe_scl(output logic [3:0] sw, output logic [3:0] mx);
    @(negedge clk); m_scl = 1'b1; wait_cyc(10);
    sw = sw_scl_dn; mx = mx_scl_dn;
    m_scl = 1'b0; wait_cyc(20);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1; wait_cyc(5); rst = 1'b0; wait_cyc(10);
    check("R5 reset: no switch channel driven", {sw_scl_dn_oe, sw_sda_dn_oe}, 8'h00);
    check("R9 reset: irq output idle", sw_irq_o, 1'b1);
    read_stat(SW_ADDR, d);
    check("R5/R10 reset read-back switch", d, 8'h00);
    read_stat(MX_ADDR, d);
    check("R5/R10 reset read-back mux", d, 8'h00);
  endtask

  task automatic t_address();
    logic ack; logic [7:0] d;
    write_sel(7'h72, 8'hFF, ack);
    check("R1 foreign address not acknowledged", ack, 1'b0);
    read_stat(SW_ADDR, d);
    check("R1 foreign write left selection", d, 8'h00);
  endtask

  task automatic t_switch_select();
    logic ack, ack2; logic [7:0] d; logic [3:0] sw, mx;
    i2c_start();
    wbyte({SW_ADDR, 1'b0}, ack);
    check("R1 own address acknowledged", ack, 1'b1);
    wbyte(8'h05, ack2);
    wait_cyc(5);
    // SCL is held low by the master here, selection not yet committed
    check("R4 no channel joined before STOP", sw_scl_dn, 4'hF);
    i2c_stop();
    @(negedge clk); m_scl = 1'b1;
    wait_cyc(2);
    check("R6 downstream still released after two edges", sw_scl_dn[0], 1'b1);
    wait_cyc(1);
    check("R6 joined channels pulled on third edge", sw_scl_dn, 4'b1010);
    m_scl = 1'b0; wait_cyc(20);
    check("R8 unjoined channels 1,3 not driven", sw_scl_dn_oe & 4'b1010, 4'b0000);
    read_stat(SW_ADDR, d);
    check("R2/R10 read-back selection", d, 8'h05);
    write_sel(SW_ADDR, 8'h0F, ack);
    probe_scl(sw, mx);
    check("R2 all four channels joined", sw, 4'h0);
  endtask

  task automatic t_switch_upward();
    logic ack;
    write_sel(SW_ADDR, 8'h05, ack);
    wait_cyc(10);
    @(negedge clk); sw_dev_scl = 4'b0100; wait_cyc(6);
    check("R7 joined channel 2 pulls upstream", scl_up, 1'b0);
    check("R7 channel 2 low reaches joined channel 0", sw_scl_dn[0], 1'b0);
    sw_dev_scl = 4'b0000; wait_cyc(10);
    check("R7 upstream released after device lets go", scl_up, 1'b1);
    sw_dev_scl = 4'b0010; wait_cyc(10);
    check("R8 unjoined channel 1 has no effect upstream", scl_up, 1'b1);
    sw_dev_scl = 4'b0000; wait_cyc(10);
  endtask

  task automatic t_mux();
    logic ack; logic [7:0] d; logic [3:0] sw, mx;
    write_sel(MX_ADDR, 8'h06, ack);
    check("R1 mux address acknowledged", ack, 1'b1);
    read_stat(MX_ADDR, d);
    check("R3/R10 mux read-back", d, 8'h06);
    probe_scl(sw, mx);
    check("R3 mux joins only channel 2", mx, 4'b1011);
    write_sel(MX_ADDR, 8'h07, ack);
    probe_scl(sw, mx);
    check("R3 mux moves to channel 3", mx, 4'b0111);
    write_sel(MX_ADDR, 8'h03, ack);
    probe_scl(sw, mx);
    check("R3 mux enable clear joins nothing", mx, 4'b1111);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    @(negedge clk); sw_irq_n = 4'b0101;
    wait_cyc(2);
    check("R9 irq unchanged after two edges", sw_irq_o, 1'b1);
    wait_cyc(1);
    check("R9 irq low on third edge", sw_irq_o, 1'b0);
    read_stat(SW_ADDR, d);
    check("R10 status nibble shows channels 1 and 3", d, 8'hA5);
    @(negedge clk); sw_irq_n = 4'hF;
    wait_cyc(3);
    check("R9 irq not latched", sw_irq_o, 1'b1);
    read_stat(SW_ADDR, d);
    check("R10 status clears with inputs", d, 8'h05);
  endtask

  task automatic t_hw_reset();
    logic [7:0] d; logic [3:0] sw, mx;
    @(negedge clk); sw_hw_rst_n = 1'b0; wait_cyc(4);
    sw_hw_rst_n = 1'b1; wait_cyc(10);
    read_stat(SW_ADDR, d);
    check("R5 hardware reset clears selection", d, 8'h00);
    probe_scl(sw, mx);
    check("R5 no channel joined after hardware reset", sw, 4'hF);
    read_stat(MX_ADDR, d);
    check("R5 other instance keeps its selection", d, 8'h03);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_address();
    t_switch_select();
    t_switch_upward();
    t_mux();
    t_irq();
    t_hw_reset();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule